// File: doc/BRIEF.md
# Masked Colour LED Chain Driver

This block drives a chain of single-wire RGB LEDs that form the face of a binary clock. Each LED in the chain keeps the first 24-bit colour word that reaches it and passes the rest down the line. The block therefore sends one word per LED, nearest LED first, and then holds the line low long enough for the whole chain to latch.

Colour is not kept per LED. The caller supplies a bit mask with one bit per LED, an "on" colour and an "off" colour. Each LED receives the on colour when its mask bit is set and the off colour when it is clear. A set-mode input replaces the on colour with full red for the frame being started. A one-cycle start strobe accepted while idle takes a snapshot of the mask, both colours and set mode. The whole frame is built from that snapshot, so the caller may change its inputs at any time. The caller usually strobes start whenever the displayed time changes.

Top module: `ledchain_mask_drv`

## Requirements
- R1: After reset, `busy` and `dout` are both 0.
- R2: A `start` sampled high while `busy` is 0 begins a frame on that clock edge: in the following cycle `busy` is 1 and `dout` is 1, because the first bit's high phase has begun.
- R3: A frame carries NUM_LEDS×24 bits (384 by default). The word for LED 0 comes first, then LED 1, and so on up to LED 15. Each word is sent from bit 23 down to bit 0. Colour words use green in bits 23:16, red in 15:8 and blue in 7:0.
- R4: Every bit occupies TBIT = 15 clock cycles and starts with the line high. A 0 bit is high for T0H = 5 cycles and a 1 bit is high for T1H = 10 cycles. The line is low for the rest of the period. Successive rising edges within a frame are exactly 15 cycles apart.
- R5: LED i receives `on_color` when `mask[i]` is 1 and `off_color` when it is 0.
- R6: When `set_mode` is 1 at the accepted start, every LED whose mask bit is 1 receives 24'h00FF00 (full red, no green or blue) instead of `on_color`.
- R7: After the accepted start, changes to `mask`, `on_color`, `off_color` and `set_mode` do not alter the frame in progress.
- R8: A `start` that arrives while `busy` is 1 is ignored. It neither restarts the frame nor queues another one.
- R9: After the last bit period, `dout` stays low for GAP_CYC = 720 cycles (60 µs at 12 MHz) with `busy` held at 1. `busy` is therefore high for exactly 384×15 + 720 = 6480 cycles per frame.
- R10: Whenever `busy` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (12 MHz for the default timing) |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Frame request strobe, acted on only while idle |
| set_mode | input | 1 | Force the on colour to red for the frame being started |
| mask | input | NUM_LEDS | Per-LED selector, bit i for LED i |
| on_color | input | 24 | Colour (G,R,B bytes) for LEDs whose mask bit is 1 |
| off_color | input | 24 | Colour (G,R,B bytes) for LEDs whose mask bit is 0 |
| dout | output | 1 | Single-wire serial data to LED 0 of the chain |
| busy | output | 1 | High from frame start until the end of the latch gap |

## Verification
The frames use several mask patterns. An irregular mask with distinct on and off colours shows that LED order and the selection per mask bit are correct. An all-clear mask with a non-zero off colour shows that the off path is not forced dark. An all-set mask with set mode on shows that the red override applies. An alternating mask with white and black colours produces long runs of 1 and 0 bits, which exposes errors in the high time and the period. One frame also has its inputs changed and start strobed in the middle. The bits decoded from the line must still match the snapshot, and no second frame may follow. This separates latching at start from sampling the live inputs.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_SEND = 2'd1,
        CH_GAP  = 2'd2
    } chain_st_e;

    // Full red in green-red-blue byte layout.
    localparam logic [23:0] RED_GRB = 24'h00FF00;

endpackage

// File: rtl/ledchain_pixel_sel.sv
// Picks the colour word of the LED being sent and the bit currently on the wire.
module ledchain_pixel_sel #(
    parameter int NUM_LEDS = 16,
    parameter int COLOR_W  = 24,
    localparam int LED_W   = $clog2(NUM_LEDS),
    localparam int BIT_W   = $clog2(COLOR_W)
) (
    input  logic [NUM_LEDS-1:0] mask,
    input  logic [COLOR_W-1:0]  on_c,
    input  logic [COLOR_W-1:0]  off_c,
    input  logic [LED_W-1:0]    led,
    input  logic [BIT_W-1:0]    bit_idx,
    output logic                bit_val
);

    logic [COLOR_W-1:0] word;

    always_comb begin
        word    = mask[led] ? on_c : off_c;
        bit_val = word[bit_idx];
    end

endmodule

// File: rtl/ledchain_bit_enc.sv
// Turns the position inside a bit period into a line level.
module ledchain_bit_enc #(
    parameter int T0H    = 5,
    parameter int T1H    = 10,
    parameter int TBIT   = 15,
    localparam int CNT_W = $clog2(TBIT)
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic             bit_val,
    output logic             level,
    output logic             period_end
);

    localparam logic [CNT_W-1:0] HI0  = CNT_W'(T0H);
    localparam logic [CNT_W-1:0] HI1  = CNT_W'(T1H);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TBIT - 1);

    always_comb begin
        level      = cnt < (bit_val ? HI1 : HI0);
        period_end = cnt == LAST;
    end

endmodule

// File: rtl/ledchain_mask_drv.sv
module ledchain_mask_drv
    import ledchain_pkg::*;
#(
    parameter int NUM_LEDS = 16,
    parameter int COLOR_W  = 24,
    parameter int T0H      = 5,
    parameter int T1H      = 10,
    parameter int TBIT     = 15,
    parameter int GAP_CYC  = 720,
    parameter logic [COLOR_W-1:0] SET_COLOR = COLOR_W'(RED_GRB)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                set_mode,
    input  logic [NUM_LEDS-1:0] mask,
    input  logic [COLOR_W-1:0]  on_color,
    input  logic [COLOR_W-1:0]  off_color,
    output logic                dout,
    output logic                busy
);

    localparam int LED_W = $clog2(NUM_LEDS);
    localparam int BIT_W = $clog2(COLOR_W);
    localparam int CNT_W = $clog2(TBIT);
    localparam int GAP_W = $clog2(GAP_CYC);

    localparam logic [LED_W-1:0] LED_TOP = LED_W'(NUM_LEDS - 1);
    localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(COLOR_W - 1);
    localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(GAP_CYC - 1);

    typedef struct packed {
        chain_st_e             st;
        logic [LED_W-1:0]      led;
        logic [BIT_W-1:0]      bit_idx;
        logic [CNT_W-1:0]      cnt;
        logic [GAP_W-1:0]      gap;
        logic [NUM_LEDS-1:0]   mask;
        logic [COLOR_W-1:0]    on_c;
        logic [COLOR_W-1:0]    off_c;
    } frame_t;

    frame_t r_q, r_d;
    logic   bit_val;
    logic   level;
    logic   period_end;

    ledchain_pixel_sel #(
        .NUM_LEDS (NUM_LEDS),
        .COLOR_W  (COLOR_W)
    ) u_sel (
        .mask    (r_q.mask),
        .on_c    (r_q.on_c),
        .off_c   (r_q.off_c),
        .led     (r_q.led),
        .bit_idx (r_q.bit_idx),
        .bit_val (bit_val)
    );

    ledchain_bit_enc #(
        .T0H  (T0H),
        .T1H  (T1H),
        .TBIT (TBIT)
    ) u_enc (
        .cnt        (r_q.cnt),
        .bit_val    (bit_val),
        .level      (level),
        .period_end (period_end)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            CH_IDLE: begin
                if (start) begin
                    // Snapshot everything the frame depends on.
                    r_d.st      = CH_SEND;
                    r_d.led     = '0;
                    r_d.bit_idx = BIT_TOP;
                    r_d.cnt     = '0;
                    r_d.mask    = mask;
                    r_d.on_c    = set_mode ? SET_COLOR : on_color;
                    r_d.off_c   = off_color;
                end
            end
            CH_SEND: begin
                if (period_end) begin
                    r_d.cnt = '0;
                    if (r_q.bit_idx == '0) begin
                        r_d.bit_idx = BIT_TOP;
                        if (r_q.led == LED_TOP) begin
                            r_d.st  = CH_GAP;
                            r_d.gap = '0;
                        end else begin
                            r_d.led = r_q.led + 1'b1;
                        end
                    end else begin
                        r_d.bit_idx = r_q.bit_idx - 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            CH_GAP: begin
                if (r_q.gap == GAP_TOP) begin
                    r_d.st = CH_IDLE;
                end else begin
                    r_d.gap = r_q.gap + 1'b1;
                end
            end
            default: r_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != CH_IDLE);
    assign dout = (r_q.st == CH_SEND) && level;

endmodule

// File: rtl/ledchain_mask_drv_chk.sv
module ledchain_mask_drv_chk #(
    parameter int NUM_LEDS = 16,
    parameter int T1H      = 10,
    parameter int TBIT     = 15,
    parameter int GAP_CYC  = 720
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [NUM_LEDS-1:0] mask,
    input logic                dout,
    input logic                busy
);

    localparam int HI_W = $clog2(T1H + 2);
    localparam int LO_W = $clog2(GAP_CYC + TBIT + 2);
    localparam logic [HI_W-1:0] HI_SAT = {HI_W{1'b1}};
    localparam logic [LO_W-1:0] LO_SAT = {LO_W{1'b1}};
    localparam logic [HI_W-1:0] HI_MAX = HI_W'(T1H);
    localparam logic [LO_W-1:0] LO_MIN = LO_W'(GAP_CYC);

    logic [HI_W-1:0] hi_run_q;
    logic [LO_W-1:0] lo_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
        end else begin
            hi_run_q <= !dout ? '0 : (hi_run_q == HI_SAT ? hi_run_q : hi_run_q + 1'b1);
            lo_run_q <= (dout || !busy) ? '0 :
                        (lo_run_q == LO_SAT ? lo_run_q : lo_run_q + 1'b1);
        end
    end

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dout);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && dout));

    // R4
    high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout |-> (hi_run_q < HI_MAX));

    // R9
    latch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (lo_run_q >= LO_MIN));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && dout) |=> busy);

endmodule

bind ledchain_mask_drv ledchain_mask_drv_chk #(
    .NUM_LEDS (NUM_LEDS),
    .T1H      (T1H),
    .TBIT     (TBIT),
    .GAP_CYC  (GAP_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .mask  (mask),
    .dout  (dout),
    .busy  (busy)
);

// File: tb/ledchain_mask_drv_bench.sv
module ledchain_mask_drv_bench;

    localparam int N      = 16;
    localparam int T0H    = 5;
    localparam int T1H    = 10;
    localparam int TBIT   = 15;
    localparam int GAP    = 720;
    localparam int BUSY_LEN = N * 24 * TBIT + GAP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          set_mode = 1'b0;
    logic [N-1:0]  mask = '0;
    logic [23:0]   on_color = '0;
    logic [23:0]   off_color = '0;
    logic          dout;
    logic          busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit exp_q[$];

    always #10 clk = ~clk;

    ledchain_mask_drv #(
        .NUM_LEDS (N),
        .T0H      (T0H),
        .T1H      (T1H),
        .TBIT     (TBIT),
        .GAP_CYC  (GAP)
    ) u_ledchain_mask_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .set_mode  (set_mode),
        .mask      (mask),
        .on_color  (on_color),
        .off_color (off_color),
        .dout      (dout),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: builds the expected bit stream, then strobes start.
    task automatic send_frame(input logic [N-1:0] m, input logic [23:0] on_c,
                              input logic [23:0] off_c, input bit setm, input bit disturb);
        logic [23:0] eff_on;
        logic [23:0] w;
        eff_on = setm ? 24'h00FF00 : on_c;   // R6 red override
        for (int led = 0; led < N; led++) begin        // R3 LED 0 first
            w = m[led] ? eff_on : off_c;               // R5 selection
            for (int b = 23; b >= 0; b--) exp_q.push_back(w[b]);
        end
        @(negedge clk);
        mask = m; on_color = on_c; off_color = off_c; set_mode = setm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && dout === 1'b1, "R2 start", {busy, dout}, 3);
        if (disturb) begin
            // R7 / R8: scramble inputs and strobe start mid-frame
            repeat (1000) @(negedge clk);
            mask = ~m; on_color = ~on_c; off_color = ~off_c; set_mode = ~setm;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (37) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        chk(exp_q.size() == 0, "R3 bits left", exp_q.size(), 0);
        repeat (60) @(negedge clk);
        chk(busy === 1'b0 && dout === 1'b0, "R8 no queued frame", {busy, dout}, 0);
    endtask

    // Monitor: decodes the line and compares with the scoreboard.
    bit prev_d = 1'b0;
    bit prev_b = 1'b0;
    bit seen_rise = 1'b0;
    int hi = 0;
    int since_rise = 0;
    int busy_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (dout && !busy) chk(1'b0, "R10 line high while idle", 1, 0);
            if (dout) hi++;
            if (prev_d && !dout) begin
                int got;
                got = (hi == T1H) ? 1 : ((hi == T0H) ? 0 : -1);
                chk(got != -1, "R4 high time", hi, T0H);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected bit", got, -1);
                end else begin
                    int e;
                    e = int'(exp_q.pop_front());
                    chk(got == e, "R3/R5/R6/R7 bit value", got, e);
                end
                hi = 0;
            end
            if (dout && !prev_d) begin
                if (seen_rise) chk(since_rise + 1 == TBIT, "R4 period", since_rise + 1, TBIT);
                since_rise = 0;
                seen_rise = 1'b1;
            end else begin
                since_rise++;
            end
            if (busy) busy_cnt++;
            if (prev_b && !busy) begin
                chk(busy_cnt == BUSY_LEN, "R9 busy length", busy_cnt, BUSY_LEN);
                busy_cnt = 0;
                seen_rise = 1'b0;
            end
            prev_d = dout;
            prev_b = busy;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && dout === 1'b0, "R1 reset", {busy, dout}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && dout === 1'b0, "R1 after release", {busy, dout}, 0);

        send_frame(16'hA5C3, 24'h123456, 24'h000000, 1'b0, 1'b0); // R5 irregular mask
        send_frame(16'h0000, 24'hFFFFFF, 24'h010203, 1'b0, 1'b0); // R5 off path
        send_frame(16'hFFFF, 24'h0000FF, 24'h000000, 1'b1, 1'b0); // R6 red
        send_frame(16'h8001, 24'hC0FFEE, 24'h0F0F0F, 1'b0, 1'b1); // R7, R8
        send_frame(16'h5555, 24'hFFFFFF, 24'h000000, 1'b0, 1'b0); // R4 long runs

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule